// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides which thread blocks become resident on a single streaming multiprocessor. Launch requests arrive one at a time from an in-order queue through a valid/ready handshake, each carrying the number of threads in the block. A request is admitted only when three limits all allow it: the per-block thread ceiling, the total resident thread budget and the number of block slots. An admitted block receives the lowest-numbered free slot, and the controller then emits one warp-creation event per cycle. Each event carries the slot, the warp index and a 32-lane active mask.

Each slot tracks how many of its warps are still outstanding. Warp-completion pulses name a slot and count it down. The slot, its threads and its block count return to the pool only when the last warp reports. The resident block and thread totals are exported as occupancy outputs. Requests that can never be legal (zero threads, or more than the per-block ceiling) are consumed at once and flagged as errors. A legal request that does not fit yet stalls the queue until enough resident blocks finish.

Top module: `tbac_admit`

## Requirements
- R1: At most 8 blocks are resident. While all 8 slots are busy, a legal head request is not accepted (`req_ready` stays 0).
- R2: The resident thread total never exceeds 1024. A legal head request whose threads would push the total past 1024 is not accepted, even when slots are free.
- R3: A request with 0 threads or more than 512 threads is consumed with `req_ready` and `req_reject` both high in the same cycle. It produces no warp event and leaves both occupancy outputs unchanged.
- R4: An admitted block of N threads yields ceil(N/32) warp events with indices 0,1,2,... in order. Every warp's mask is all ones (0xFFFFFFFF), except that the last warp's mask has its low N mod 32 bits set when N mod 32 is not 0.
- R5: A block's slot, thread count and block count are released only when all of its warps have reported done. Earlier done pulses leave the occupancy outputs unchanged.
- R6: Admission is strictly in order. While the head request is legal but does not fit, `req_ready` stays 0 and nothing behind it can be taken.
- R7: An admitted block is given the lowest-numbered free slot (0 to 7), and all of its warp events carry that slot.
- R8: `req_ready` is high only in a cycle where `req_valid` is high and the head is admitted or rejected. `req_reject` is high only together with `req_ready`.
- R9: A done pulse naming a slot with no outstanding warps has no effect on occupancy or on slot assignment.
- R10: The first warp event of a block appears in the cycle after its admission, and the remaining events follow on consecutive cycles. No new block is admitted while warps of a previous block are still being emitted.
- R11: `occ_blocks` and `occ_threads` reflect an admission or a release in the cycle after it takes place, and they read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Head launch request present |
| req_threads | input | 11 | Thread count of the head request |
| req_ready | output | 1 | Head request consumed this cycle |
| req_reject | output | 1 | Head request consumed as illegal |
| warp_valid | output | 1 | Warp-creation event present |
| warp_slot | output | 3 | Slot of the block owning the warp |
| warp_idx | output | 4 | Warp index within its block |
| warp_mask | output | 32 | Active-lane mask of the warp |
| done_valid | input | 1 | A warp has completed |
| done_slot | input | 3 | Slot of the completed warp |
| occ_blocks | output | 4 | Resident block count |
| occ_threads | output | 11 | Resident thread total |

## Verification
The bench fills all eight slots with 64-thread blocks to show that the slot limit alone stalls admission at 512 threads. It then loads four 256-thread blocks to show that the thread budget alone stalls admission with slots still free. A controller that checked only one limit would admit the ninth or the fifth block. Partial completion is tested by sending all but the last done pulse and confirming that occupancy holds. A design that released a slot on the first pulse would free a slot early and admit a block into a slot that is still running. The bench also exercises partial and exact-multiple masks (1, 32, 70 threads), illegal sizes of 0 and 513, lowest-slot reuse after a hole opens in the middle, and done pulses aimed at idle slots. These expose off-by-one mask generation, acceptance of illegal sizes, and counters that wrap below zero.

// File: rtl/tbac_pkg.sv
// Package: default sizing for the thread block admission controller.
// Assumes: lane count is a power of two.
package tbac_pkg;
    parameter int DEF_SLOTS      = 8;
    parameter int DEF_SM_THREADS = 1024;
    parameter int DEF_BLK_THREADS = 512;
    parameter int DEF_LANES      = 32;

    // Ceiling division used for sizing derived widths.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/tbac_warp_gen.sv
// Module: tbac_warp_gen
// Emits one warp-creation event per cycle for the most recently admitted
// block: index counts up from 0, the last warp carries a partial mask when
// the thread count is not a multiple of the lane count.
// Assumes: load is only raised while idle is high.
module tbac_warp_gen #(
    parameter int LANES  = 32,
    parameter int SLOT_W = 3,
    parameter int WIDX_W = 4,
    parameter int WCNT_W = 5,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] load_slot,
    input  logic [WCNT_W-1:0] load_warps,
    input  logic [LANE_W-1:0] load_rem,
    output logic              idle,
    output logic              warp_valid,
    output logic [SLOT_W-1:0] warp_slot,
    output logic [WIDX_W-1:0] warp_idx,
    output logic [LANES-1:0]  warp_mask
);
    logic [WCNT_W-1:0] left_q;
    logic [WIDX_W-1:0] idx_q;
    logic [SLOT_W-1:0] slot_q;
    logic [LANE_W-1:0] rem_q;
    logic [LANES-1:0]  part_mask;

    // Emission state: load a new block or step through its warps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            idx_q  <= '0;
            slot_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            left_q <= load_warps;
            idx_q  <= '0;
            slot_q <= load_slot;
            rem_q  <= load_rem;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Partial mask with the low rem_q lanes active.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            part_mask[i] = (i < int'(rem_q));
        end
    end

    // Event outputs derived from the emission state.
    always_comb begin
        idle       = (left_q == '0);
        warp_valid = (left_q != '0);
        warp_slot  = slot_q;
        warp_idx   = idx_q;
        warp_mask  = ((left_q == WCNT_W'(1)) && (rem_q != '0)) ? part_mask : '1;
    end

    // R4: an emitted warp always has at least one active lane.
    a_r4_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid |-> (warp_mask != '0));
    // R10: a new block is never loaded over one still being emitted.
    a_r10_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> idle);
    // R10: warps of a block come on back-to-back cycles with rising index.
    a_r10_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_valid && left_q > WCNT_W'(1)) |=> (warp_valid && warp_idx == $past(warp_idx) + 1'b1));
endmodule

// File: rtl/tbac_slot_table.sv
// Module: tbac_slot_table
// Per-slot record of outstanding warps and thread count. Picks the lowest
// free slot, counts done pulses down, and signals a release with the
// slot's thread count when its last warp reports.
// Assumes: at most one done pulse per cycle; alloc only when free_any.
module tbac_slot_table #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 3,
    parameter int THR_W  = 11,
    parameter int WCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [THR_W-1:0]  alloc_threads,
    input  logic [WCNT_W-1:0] alloc_warps,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot,
    output logic              free_any,
    output logic [SLOT_W-1:0] free_slot,
    output logic              rel_valid,
    output logic [THR_W-1:0]  rel_threads
);
    logic [WCNT_W-1:0] cnt_q [SLOTS];
    logic [THR_W-1:0]  thr_q [SLOTS];
    logic [SLOTS-1:0]  busy;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Slot record: claim on alloc, count down on a matching done.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
                thr_q[g] <= '0;
            end else if (alloc && free_slot == SLOT_W'(g)) begin
                cnt_q[g] <= alloc_warps;
                thr_q[g] <= alloc_threads;
            end else if (done_valid && done_slot == SLOT_W'(g) && cnt_q[g] != '0) begin
                cnt_q[g] <= cnt_q[g] - 1'b1;
            end
        end
        assign busy[g] = (cnt_q[g] != '0);
    end

    // Lowest-numbered free slot search.
    always_comb begin
        free_any  = 1'b0;
        free_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_any  = 1'b1;
                free_slot = SLOT_W'(i);
            end
        end
    end

    // Release when the final outstanding warp of a slot reports.
    always_comb begin
        rel_valid   = done_valid && (cnt_q[done_slot] == WCNT_W'(1));
        rel_threads = thr_q[done_slot];
    end

    // R7: allocation only ever targets a slot that is free.
    a_r7_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (free_any && !busy[free_slot]));
    // R5: a done pulse that is not the last keeps the slot busy.
    a_r5_partial_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && cnt_q[done_slot] > WCNT_W'(1)) |=> busy[$past(done_slot)]);
    // R9: a done pulse to an idle slot does not disturb it.
    a_r9_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !busy[done_slot] && !(alloc && free_slot == done_slot))
        |=> !busy[$past(done_slot)]);
endmodule

// File: rtl/tbac_admit.sv
// Module: tbac_admit (top)
// Admission controller for one streaming multiprocessor: checks the head
// launch request against the per-block, per-SM thread and slot limits,
// admits it into the lowest free slot, emits its warps, and keeps the
// resident block and thread totals.
// Assumes: requests are presented in queue order and held until ready.
module tbac_admit
    import tbac_pkg::*;
#(
    parameter int SLOTS       = DEF_SLOTS,
    parameter int SM_THREADS  = DEF_SM_THREADS,
    parameter int BLK_THREADS = DEF_BLK_THREADS,
    parameter int LANES       = DEF_LANES,
    parameter int SLOT_W      = $clog2(SLOTS),
    parameter int THR_W       = $clog2(SM_THREADS + 1),
    parameter int BLK_W       = $clog2(SLOTS + 1),
    parameter int WIDX_W      = $clog2(ceil_div(BLK_THREADS, LANES)),
    parameter int WCNT_W      = $clog2(ceil_div(BLK_THREADS, LANES) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [THR_W-1:0]  req_threads,
    output logic              req_ready,
    output logic              req_reject,
    output logic              warp_valid,
    output logic [SLOT_W-1:0] warp_slot,
    output logic [WIDX_W-1:0] warp_idx,
    output logic [LANES-1:0]  warp_mask,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot,
    output logic [BLK_W-1:0]  occ_blocks,
    output logic [THR_W-1:0]  occ_threads
);
    localparam int LANE_W = $clog2(LANES);

    logic              legal, fits, admit, gen_idle;
    logic              free_any, rel_valid;
    logic [SLOT_W-1:0] free_slot;
    logic [THR_W-1:0]  rel_threads;
    logic [WCNT_W-1:0] need_warps;
    logic [THR_W:0]    sum_threads;

    // Limit checks and the handshake for the head request.
    always_comb begin
        legal       = (req_threads != '0) && (int'(req_threads) <= BLK_THREADS);
        sum_threads = {1'b0, occ_threads} + {1'b0, req_threads};
        fits        = free_any && (int'(sum_threads) <= SM_THREADS);
        admit       = req_valid && legal && fits && gen_idle;
        req_reject  = req_valid && !legal;
        req_ready   = admit || req_reject;
        need_warps  = WCNT_W'(({1'b0, req_threads} + (THR_W+1)'(LANES - 1)) >> LANE_W);
    end

    // Resident totals: add on admission, subtract on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_threads <= '0;
            occ_blocks  <= '0;
        end else begin
            occ_threads <= occ_threads + (admit ? req_threads : '0)
                           - (rel_valid ? rel_threads : '0);
            occ_blocks  <= occ_blocks + BLK_W'(admit) - BLK_W'(rel_valid);
        end
    end

    tbac_slot_table #(
        .SLOTS(SLOTS), .SLOT_W(SLOT_W), .THR_W(THR_W), .WCNT_W(WCNT_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc(admit), .alloc_threads(req_threads), .alloc_warps(need_warps),
        .done_valid(done_valid), .done_slot(done_slot),
        .free_any(free_any), .free_slot(free_slot),
        .rel_valid(rel_valid), .rel_threads(rel_threads)
    );

    tbac_warp_gen #(
        .LANES(LANES), .SLOT_W(SLOT_W), .WIDX_W(WIDX_W), .WCNT_W(WCNT_W), .LANE_W(LANE_W)
    ) u_gen (
        .clk(clk), .rst_n(rst_n),
        .load(admit), .load_slot(free_slot), .load_warps(need_warps),
        .load_rem(req_threads[LANE_W-1:0]),
        .idle(gen_idle), .warp_valid(warp_valid), .warp_slot(warp_slot),
        .warp_idx(warp_idx), .warp_mask(warp_mask)
    );

    // R1: resident block count stays within the slot count.
    a_r1_block_limit: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ_blocks) <= SLOTS);
    // R2: resident thread total stays within the budget.
    a_r2_thread_limit: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ_threads) <= SM_THREADS);
    // R8: ready never without a request, reject never without ready.
    a_r8_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready |-> req_valid) and (req_reject |-> req_ready));
    // R3: a rejected request does not start warp emission.
    a_r3_no_warps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_reject && gen_idle) |=> !warp_valid);
    // R10/R11: admission shows a warp and a nonzero block count next cycle.
    a_r11_after_admit: assert property (@(posedge clk) disable iff (!rst_n)
        admit |=> (warp_valid && occ_blocks != '0));
endmodule

// File: tb/tbac_admit_bench.sv
module tbac_admit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [10:0] req_threads = '0;
    logic        req_ready, req_reject;
    logic        warp_valid;
    logic [2:0]  warp_slot;
    logic [3:0]  warp_idx;
    logic [31:0] warp_mask;
    logic        done_valid = 1'b0;
    logic [2:0]  done_slot = '0;
    logic [3:0]  occ_blocks;
    logic [10:0] occ_threads;

    int checks = 0;
    int fails  = 0;
    int nw;
    int rec_slot [32];
    int rec_idx  [32];
    logic [31:0] rec_mask [32];
    int exp_blocks = 0;
    int exp_threads = 0;

    always #5 clk = ~clk;

    tbac_admit u_tbac_admit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_threads(req_threads),
        .req_ready(req_ready), .req_reject(req_reject),
        .warp_valid(warp_valid), .warp_slot(warp_slot),
        .warp_idx(warp_idx), .warp_mask(warp_mask),
        .done_valid(done_valid), .done_slot(done_slot),
        .occ_blocks(occ_blocks), .occ_threads(occ_threads)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_occ(input string req);
        check(req, occ_blocks, exp_blocks);
        check(req, occ_threads, exp_threads);
    endtask

    // Present a request, wait up to maxwait cycles, collect its warps.
    task automatic push(input int thr, input int maxwait, output bit got, output bit rej);
        got = 0; rej = 0; nw = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_threads = 11'(thr);
        for (int k = 0; k < maxwait && !got; k++) begin
            #1;
            if (req_ready) begin
                got = 1;
                rej = req_reject;
            end else begin
                @(negedge clk);
            end
        end
        if (got) begin
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            while (warp_valid && nw < 32) begin
                rec_slot[nw] = warp_slot;
                rec_idx[nw]  = warp_idx;
                rec_mask[nw] = warp_mask;
                nw++;
                @(negedge clk);
            end
            if (!rej) begin
                exp_blocks++;
                exp_threads += thr;
            end
        end else begin
            req_valid = 1'b0;
        end
    endtask

    // Compare the collected warps with what a block of thr threads needs.
    task automatic check_warps(input string req, input int thr, input int slot);
        int n;
        int r;
        logic [31:0] m;
        n = (thr + 31) / 32;
        r = thr % 32;
        check(req, nw, n);
        for (int i = 0; i < nw && i < n; i++) begin
            m = (i == n - 1 && r != 0) ? ((32'h1 << r) - 1) : 32'hFFFF_FFFF;
            check(req, rec_slot[i], slot);
            check(req, rec_idx[i], i);
            check(req, rec_mask[i], m);
        end
    endtask

    task automatic send_done(input int slot);
        @(negedge clk);
        done_valid = 1'b1;
        done_slot = 3'(slot);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic retire(input int slot, input int warps, input int thr);
        for (int i = 0; i < warps; i++) send_done(slot);
        exp_blocks--;
        exp_threads -= thr;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R11 reset blocks", occ_blocks, 0);
        check("R11 reset threads", occ_threads, 0);
        check("R8 ready idle", req_ready, 0);
        check("R10 no warp at reset", warp_valid, 0);
    endtask

    task automatic t_single;
        bit got, rej;
        push(70, 5, got, rej);
        check("R4 admit 70", got & !rej, 1);
        check_warps("R4 R7 R10 warps of 70", 70, 0);
        check_occ("R11 occ after 70");
        send_done(0);
        send_done(0);
        check_occ("R5 partial done holds");
        retire(0, 1, 70);
        check_occ("R5 release after last");
        push(1, 5, got, rej);
        check_warps("R4 single lane", 1, 0);
        retire(0, 1, 1);
        push(32, 5, got, rej);
        check_warps("R4 exact warp", 32, 0);
        retire(0, 1, 32);
        check_occ("R11 empty again");
    endtask

    task automatic t_reject;
        bit got, rej;
        push(513, 5, got, rej);
        check("R3 reject 513", rej, 1);
        check("R3 no warps 513", nw, 0);
        check_occ("R3 occ after 513");
        push(0, 5, got, rej);
        check("R3 reject zero", rej, 1);
        check("R3 no warps zero", nw, 0);
        push(512, 5, got, rej);
        check("R3 512 legal", got & !rej, 1);
        check_warps("R4 warps of 512", 512, 0);
        retire(0, 16, 512);
        check_occ("R3 occ clean");
    endtask

    task automatic t_block_limit;
        bit got, rej;
        for (int s = 0; s < 8; s++) begin
            push(64, 5, got, rej);
            check_warps("R7 slot order", 64, s);
        end
        check_occ("R1 eight resident");
        push(64, 10, got, rej);
        check("R1 ninth stalls", got, 0);
        send_done(3);
        check_occ("R5 one of two");
        retire(3, 1, 64);
        check_occ("R5 slot 3 freed");
        push(64, 5, got, rej);
        check("R1 admit after free", got, 1);
        check_warps("R7 reuse slot 3", 64, 3);
        for (int s = 0; s < 8; s++) retire(s, 2, 64);
        check_occ("R11 block test clean");
    endtask

    task automatic t_thread_limit;
        bit got, rej;
        for (int s = 0; s < 4; s++) begin
            push(256, 12, got, rej);
            check_warps("R2 256 admit", 256, s);
        end
        check_occ("R2 1024 resident");
        push(32, 12, got, rej);
        check("R2 R6 head stalls", got, 0);
        check("R8 no ready while stalled", req_ready, 0);
        retire(2, 8, 256);
        push(256, 5, got, rej);
        check("R6 head admitted", got, 1);
        check_warps("R7 slot 2 again", 256, 2);
        for (int s = 0; s < 4; s++) retire(s, 8, 256);
        check_occ("R11 thread test clean");
    endtask

    task automatic t_idle_done;
        bit got, rej;
        send_done(5);
        check_occ("R9 idle done no change");
        push(32, 5, got, rej);
        check_warps("R9 slot 0 still chosen", 32, 0);
        send_done(5);
        check_occ("R9 idle done with resident");
        retire(0, 1, 32);
        check_occ("R9 clean");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_reject();
        t_block_limit();
        t_thread_limit();
        t_idle_done();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule